// File: doc/BRIEF.md
# Programmable Interval Timer

This block is a 16-bit down-counting timer for a host that reaches it through byte-wide read and write strobes. The host writes the reload value into two byte registers and then issues commands through a control register. A start loads the counter from the reload value. The counter then decrements once per tick until it expires. On expiry the block raises an interrupt flag. In one-shot mode the timer then stops. In periodic mode it reloads and runs again.

A tick is either every cycle of the block clock (internal source) or one rising edge of an external timer clock. The external clock is brought into the clock domain through a two-flop synchronizer followed by an edge detector. A read of the control register returns the pending flag and clears it. The host never reads back the live count. A reload value of zero keeps the timer from running.

Top module: `interval_timer`

## Requirements
- R1: After reset, both reload bytes read 0x00, the control register reads 0x00, `irq` is low, the timer is stopped, one-shot mode is selected and the internal tick source is selected.
- R2: Address 0 holds reload bits 7:0 (bit 0 is the LSB) and address 1 holds bits 15:8. A read returns the programmed byte on `rdata` one cycle after `rd_en`, never the live count. Address 3 reads 0x00.
- R3: A start command issued while the reload value is zero is ignored, and the timer stays stopped.
- R4: In periodic mode, if the reload value is zero when the counter expires, the timer stops instead of reloading.
- R5: With the internal source and a reload value N, `irq` rises on the Nth clock edge after the edge that accepts the start write.
- R6: A read of the control register (address 2) returns 0x01 while an interrupt is pending and 0x00 otherwise, and it clears the pending flag. `irq` mirrors the flag. An expiry in the same cycle as that read leaves the flag set.
- R7: In one-shot mode the timer stops after its first expiry and raises no further interrupt.
- R8: In periodic mode the timer reloads on expiry and expires again every N ticks.
- R9: A stop command halts counting, and no interrupt follows.
- R10: The reset command clears the count, the running state and the pending flag. It keeps the mode and tick-source selections.
- R11: With the external source, each rising edge of `ext_clk_in` is one tick, and `irq` rises three clock edges after the Nth edge is presented. Without edges, the counter does not advance.
- R12: Commands are taken from `wdata[3:0]` on a write to address 2, and bits 7:4 are ignored. The codes are 1 start, 2 stop, 3 one-shot, 4 periodic, 5 internal source, 6 external source and 7 reset. Codes 0 and 8 to 15 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, also the internal tick source |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered |
| ext_clk_in | input | 1 | External timer clock, asynchronous |
| irq | output | 1 | Time-out interrupt pending |

## Verification
Read data is due one cycle after the read strobe. The bench drives every input at a falling edge and samples `rdata` at the next falling edge. A start write is accepted on the next rising edge. The bench counts falling edges from there, so with the internal source `irq` must appear exactly N edges later. An external edge needs two synchronizer edges plus the counting edge, so the bench checks `irq` low two cycles after presenting the Nth edge and high on the third. Periodic runs are timed against twice the reload value, including the cycle spent on the clearing read.

// File: rtl/itm_pkg.sv
package itm_pkg;

  typedef enum logic [3:0] {
    CMD_NOP      = 4'h0,
    CMD_START    = 4'h1,
    CMD_STOP     = 4'h2,
    CMD_ONESHOT  = 4'h3,
    CMD_PERIODIC = 4'h4,
    CMD_SRC_INT  = 4'h5,
    CMD_SRC_EXT  = 4'h6,
    CMD_RESET    = 4'h7
  } itm_cmd_e;

  typedef struct packed {
    logic start;
    logic stop;
    logic set_oneshot;
    logic set_periodic;
    logic set_int;
    logic set_ext;
    logic reset;
  } itm_cmd_t;

endpackage

// File: rtl/itm_regs.sv
module itm_regs
  import itm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              pending,
  output logic [CNT_W-1:0]  reload,
  output itm_cmd_t          cmd,
  output logic              pend_clr,
  output logic [BYTE_W-1:0] rdata
);

  localparam int NBYTES = CNT_W / BYTE_W;
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(NBYTES);

  // reload byte registers, one per byte lane
  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    logic              byte_en;
    logic [BYTE_W-1:0] byte_q;
    assign byte_en = wr_en && (addr == ADDR_W'(b));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        byte_q <= '0;
      end else if (byte_en) begin
        byte_q <= wdata;
      end
    end
    assign reload[b*BYTE_W +: BYTE_W] = byte_q;
  end

  // command decode: low nibble only
  always_comb begin
    cmd = '0;
    if (wr_en && (addr == CTRL_A)) begin
      unique case (itm_cmd_e'(wdata[3:0]))
        CMD_START:    cmd.start        = 1'b1;
        CMD_STOP:     cmd.stop         = 1'b1;
        CMD_ONESHOT:  cmd.set_oneshot  = 1'b1;
        CMD_PERIODIC: cmd.set_periodic = 1'b1;
        CMD_SRC_INT:  cmd.set_int      = 1'b1;
        CMD_SRC_EXT:  cmd.set_ext      = 1'b1;
        CMD_RESET:    cmd.reset        = 1'b1;
        default:      cmd = '0;
      endcase
    end
  end

  assign pend_clr = rd_en && (addr == CTRL_A);

  // read mux
  logic [BYTE_W-1:0] rd_next;
  always_comb begin
    rd_next = '0;
    for (int b = 0; b < NBYTES; b++) begin
      if (addr == ADDR_W'(b)) rd_next = reload[b*BYTE_W +: BYTE_W];
    end
    if (addr == CTRL_A) rd_next = BYTE_W'(pending);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= rd_next;
    end
  end

endmodule

// File: rtl/itm_tick.sv
module itm_tick #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_clk_in,
  input  logic use_ext,
  output logic tick
);

  localparam int SH_W = SYNC_STAGES + 1;

  logic [SH_W-1:0] sh_q;
  logic [SH_W-1:0] sh_d;
  logic            ext_rise;

  assign sh_d = {sh_q[SH_W-2:0], ext_clk_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign ext_rise = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
  assign tick     = use_ext ? ext_rise : 1'b1;

endmodule

// File: rtl/itm_core.sv
module itm_core
  import itm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  itm_cmd_t         cmd,
  input  logic [CNT_W-1:0] reload,
  input  logic             tick,
  input  logic             pend_clr,
  output logic             running,
  output logic [CNT_W-1:0] count,
  output logic             oneshot,
  output logic             use_ext,
  output logic             pending
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             run_d;
  logic [CNT_W-1:0] cnt_d;
  logic             os_d;
  logic             ext_d;
  logic             pend_d;
  logic             expire;

  assign expire = running && tick && (count == ONE);

  always_comb begin
    run_d  = running;
    cnt_d  = count;
    os_d   = oneshot;
    ext_d  = use_ext;
    pend_d = pending;

    if (pend_clr)         pend_d = 1'b0;
    if (cmd.set_oneshot)  os_d   = 1'b1;
    if (cmd.set_periodic) os_d   = 1'b0;
    if (cmd.set_int)      ext_d  = 1'b0;
    if (cmd.set_ext)      ext_d  = 1'b1;

    if (cmd.reset) begin
      run_d  = 1'b0;
      cnt_d  = '0;
      pend_d = 1'b0;
    end else if (cmd.start) begin
      if (reload != '0) begin
        run_d = 1'b1;
        cnt_d = reload;
      end
    end else if (cmd.stop) begin
      run_d = 1'b0;
    end else if (expire) begin
      pend_d = 1'b1;
      if (oneshot || (reload == '0)) begin
        run_d = 1'b0;
        cnt_d = '0;
      end else begin
        cnt_d = reload;
      end
    end else if (running && tick) begin
      cnt_d = count - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      count   <= '0;
      oneshot <= 1'b1;
      use_ext <= 1'b0;
      pending <= 1'b0;
    end else begin
      running <= run_d;
      count   <= cnt_d;
      oneshot <= os_d;
      use_ext <= ext_d;
      pending <= pend_d;
    end
  end

endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import itm_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int BYTE_W      = 8,
  parameter int ADDR_W      = $clog2(CNT_W / BYTE_W + 1),
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  input  logic              ext_clk_in,
  output logic              irq
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sh;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sh <= '0;
    end else begin
      rst_sh <= {rst_sh[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_sh[1];

  itm_cmd_t         cmd;
  logic [CNT_W-1:0] reload;
  logic [CNT_W-1:0] count;
  logic             pend_clr;
  logic             pending;
  logic             running;
  logic             oneshot;
  logic             use_ext;
  logic             tick;

  itm_regs #(
    .CNT_W (CNT_W),
    .BYTE_W(BYTE_W),
    .ADDR_W(ADDR_W)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wdata   (wdata),
    .pending (pending),
    .reload  (reload),
    .cmd     (cmd),
    .pend_clr(pend_clr),
    .rdata   (rdata)
  );

  itm_tick #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_tick (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .ext_clk_in(ext_clk_in),
    .use_ext   (use_ext),
    .tick      (tick)
  );

  itm_core #(
    .CNT_W(CNT_W)
  ) u_core (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .cmd     (cmd),
    .reload  (reload),
    .tick    (tick),
    .pend_clr(pend_clr),
    .running (running),
    .count   (count),
    .oneshot (oneshot),
    .use_ext (use_ext),
    .pending (pending)
  );

  assign irq = pending;

endmodule

// File: rtl/interval_timer_chk.sv
module interval_timer_chk #(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [BYTE_W-1:0] wdata,
  input logic [BYTE_W-1:0] rdata,
  input logic              irq,
  input logic              running,
  input logic [CNT_W-1:0]  count,
  input logic              tick,
  input logic              oneshot,
  input logic [CNT_W-1:0]  reload
);

  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CNT_W / BYTE_W);
  localparam logic [CNT_W-1:0]  ONE    = CNT_W'(1);

  logic ctrl_wr;
  logic ctrl_rd;
  logic exp_now;
  assign ctrl_wr = wr_en && (addr == CTRL_A);
  assign ctrl_rd = rd_en && (addr == CTRL_A);
  assign exp_now = running && tick && (count == ONE);

  a_r2_low_byte_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == '0) |=> rdata == $past(reload[BYTE_W-1:0]));

  a_r3_zero_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && wdata[3:0] == 4'h1 && reload == '0 && !running) |=> !running);

  a_r4_running_count_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> count != '0);

  a_r6_read_returns_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rd |=> rdata == BYTE_W'($past(irq)));

  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rd && !exp_now) |=> !irq);

  a_r7_oneshot_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (exp_now && oneshot && !wr_en) |=> (!running && irq));

  a_r8_periodic_reloads: assert property (@(posedge clk) disable iff (!rst_n)
    (exp_now && !oneshot && reload != '0 && !wr_en) |=>
      (running && irq && count == $past(reload)));

  a_r11_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !tick && !wr_en) |=> $stable(count));

endmodule

bind interval_timer interval_timer_chk #(
  .CNT_W (CNT_W),
  .BYTE_W(BYTE_W),
  .ADDR_W(ADDR_W)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_sync_n),
  .wr_en  (wr_en),
  .rd_en  (rd_en),
  .addr   (addr),
  .wdata  (wdata),
  .rdata  (rdata),
  .irq    (irq),
  .running(running),
  .count  (count),
  .tick   (tick),
  .oneshot(oneshot),
  .reload (reload)
);

// File: tb/tb_interval_timer.sv
`timescale 1ns/1ps
module tb_interval_timer;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, rd_en;
  logic [1:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       ext_clk_in;
  logic       irq;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  always #5 clk = ~clk;

  interval_timer dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ext_clk_in(ext_clk_in), .irq(irq)
  );

  function automatic int exp_ctrl(input bit pend);
    return pend ? 32'h01 : 32'h00;
  endfunction

  function automatic int exp_periodic_gap(input int n, input int used);
    return 2 * n - used;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_irq(input int max, output int c);
    c = 0;
    while (!irq && c < max) begin
      @(negedge clk);
      c++;
    end
  endtask

  task automatic set_reload(input int n);
    wr(2'd0, n[7:0]);
    wr(2'd1, n[15:8]);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #2ms;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    int c, n;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    ext_clk_in = 1'b0;
    idle(5);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    chk("R1 irq", irq, 0);
    rd(2'd0, d); chk("R1 reload lo", d, 0);
    rd(2'd1, d); chk("R1 reload hi", d, 0);
    rd(2'd2, d); chk("R1 ctrl", d, exp_ctrl(0));

    // R3 start with zero reload is ignored
    wr(2'd2, 8'h01);
    idle(20);
    chk("R3 irq after zero-reload start", irq, 0);

    // R2 readback, random values; R5/R7 one-shot timing (default mode, R1)
    for (int k = 0; k < 8; k++) begin
      n = $urandom_range(3, 300);
      set_reload(n);
      rd(2'd0, d); chk("R2 lo readback", d, n & 8'hff);
      rd(2'd1, d); chk("R2 hi readback", d, (n >> 8) & 8'hff);
      wr(2'd2, 8'h01);
      wait_irq(400, c);
      chk("R5 one-shot expiry cycles", c, n);
      rd(2'd0, d); chk("R2 readback not live count", d, n & 8'hff);
      rd(2'd2, d); chk("R6 ctrl pending", d, exp_ctrl(1));
      chk("R6 irq cleared", irq, 0);
      rd(2'd2, d); chk("R6 ctrl idle", d, exp_ctrl(0));
    end
    rd(2'd3, d); chk("R2 unused address", d, 0);
    idle(2 * 300);
    chk("R7 one-shot no second expiry", irq, 0);

    // R8 periodic
    n = 7;
    set_reload(n);
    wr(2'd2, 8'h04);
    wr(2'd2, 8'h01);
    wait_irq(50, c);
    chk("R8 first period", c, n);
    rd(2'd2, d); chk("R6 ctrl pending periodic", d, exp_ctrl(1));
    wait_irq(50, c);
    chk("R8 second period", c, exp_periodic_gap(n, n + 1));
    rd(2'd2, d);
    wait_irq(50, c);
    chk("R8 third period", c, n - 1);
    wr(2'd2, 8'h02);
    rd(2'd2, d);

    // R6 expiry in the same cycle as the clearing read
    n = 4;
    set_reload(n);
    wr(2'd2, 8'h01);
    idle(n - 1);
    rd(2'd2, d);
    chk("R6 read before set sees 0", d, exp_ctrl(0));
    chk("R6 set wins over clear", irq, 1);
    wr(2'd2, 8'h02);
    rd(2'd2, d); chk("R6 clear after collision", d, exp_ctrl(1));

    // R9 stop
    n = 20;
    set_reload(n);
    wr(2'd2, 8'h01);
    idle(10);
    wr(2'd2, 8'h02);
    idle(3 * n);
    chk("R9 no irq after stop", irq, 0);
    rd(2'd2, d); chk("R9 ctrl after stop", d, exp_ctrl(0));

    // R4 zero reload at expiry stops periodic timer
    wr(2'd2, 8'h01);
    set_reload(0);
    wait_irq(50, c);
    chk("R4 expiry with cleared reload", c, n - 2);
    rd(2'd2, d);
    idle(3 * n);
    chk("R4 no reload from zero", irq, 0);

    // R10 reset command, mode kept
    n = 12;
    set_reload(n);
    wr(2'd2, 8'h03);
    wr(2'd2, 8'h01);
    wait_irq(50, c);
    wr(2'd2, 8'h07);
    chk("R10 reset clears pending", irq, 0);
    wr(2'd2, 8'h01);
    idle(5);
    wr(2'd2, 8'h07);
    idle(3 * n);
    chk("R10 reset stops count", irq, 0);
    wr(2'd2, 8'h01);
    wait_irq(50, c);
    chk("R10 fresh count after reset", c, n);
    rd(2'd2, d);
    idle(3 * n);
    chk("R10 one-shot mode kept", irq, 0);

    // R12 unused codes and upper nibble
    n = 6;
    set_reload(n);
    wr(2'd2, 8'h00);
    for (int v = 8; v < 16; v++) wr(2'd2, 8'(v));
    idle(20);
    chk("R12 unused codes do nothing", irq, 0);
    wr(2'd2, 8'hA1);
    wait_irq(50, c);
    chk("R12 upper nibble ignored", c, n);
    rd(2'd2, d);

    // R11 external tick source
    n = 5;
    set_reload(n);
    wr(2'd2, 8'h06);
    wr(2'd2, 8'h01);
    idle(30);
    chk("R11 no edges no expiry", irq, 0);
    for (int p = 1; p < n; p++) begin
      ext_clk_in = 1'b1; idle(2);
      ext_clk_in = 1'b0; idle(2);
    end
    idle(4);
    chk("R11 before last edge", irq, 0);
    ext_clk_in = 1'b1;
    idle(2);
    chk("R11 two cycles after edge", irq, 0);
    idle(1);
    chk("R11 three cycles after edge", irq, 1);
    ext_clk_in = 1'b0;
    rd(2'd2, d);
    wr(2'd2, 8'h05);
    wr(2'd2, 8'h01);
    wait_irq(50, c);
    chk("R12 back to internal source", c, n);
    rd(2'd2, d);

    idle(5);
    finish_run();
  end

endmodule